// File: doc/BRIEF.md
# Floating-Point Mode Control Register with Decode-Side Resolution

This block holds the floating-point control and status word of a core: sticky exception flags, a dynamic rounding mode, and a two-bit accuracy-mode selector placed in bits that were previously reserved. Software reads and writes the word through a CSR port. A field selector lets it write the whole word, or only the flags, the rounding mode or the accuracy mode. Exception flags reported by the floating-point datapath are ORed into the sticky field on every valid completion.

The decoder uses a separate check port. It presents the instruction's static rounding-mode field and an operation-class code. In the same cycle the block returns the effective rounding mode, the effective accuracy mode, and an illegal-instruction trap request. A trap is raised for two reasons. The first is dynamic rounding requested while the stored rounding mode is invalid. The second is an accuracy-mode and operation-class pair that a synthesis-time support matrix marks as unsupported. Accuracy mode 00, IEEE-compliant, is always treated as supported.

Top module: `fpmode_csr`

## Requirements
- R1: After reset the CSR reads 0: flags 00000, rounding mode 000, accuracy mode 00.
- R2: The read word places flags at bits [4:0], rounding mode at bits [7:5] and accuracy mode at bits [9:8]. Bits [31:10] always read 0, and writes to them have no effect.
- R3: The write selector `csr_wr_sel` chooses what a write updates. 00 loads all three fields from `csr_wr_data[9:0]`. 01 loads only the flags from `csr_wr_data[4:0]`. 10 loads only the rounding mode from `csr_wr_data[2:0]`. 11 loads only the accuracy mode from `csr_wr_data[1:0]`. The update is visible on the read port after the next rising clock edge.
- R4: When `exc_valid` is 1, `exc_flags` is ORed into the flag field at the clock edge. Flags are sticky and stay set until software writes them. When `exc_valid` is 0, `exc_flags` has no effect.
- R5: A CSR write with selector 00 or 01 takes priority over flag accumulation in the same cycle. A write with selector 10 or 11 does not block accumulation in that cycle.
- R6: `eff_rm` equals `chk_rm` when `chk_rm` is not 111. When `chk_rm` is 111, `eff_rm` equals the stored rounding mode.
- R7: With `chk_valid` high, `chk_rm` = 111 and a stored rounding mode of 101, 110 or 111, `chk_trap` is 1.
- R8: `eff_acc` equals the stored accuracy mode. With `chk_valid` high, `chk_trap` is 1 when bit [mode*NUM_CLASSES + chk_class] of `SUPPORT_MAP` is 0 for a mode other than 00.
- R9: Accuracy mode 00 is supported for every operation class, whatever the low row of `SUPPORT_MAP` holds.
- R10: `chk_trap` is 0 whenever `chk_valid` is 0. All check outputs are combinational, within the same cycle, from the check inputs and the current register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csr_wr_en | input | 1 | CSR write strobe |
| csr_wr_sel | input | 2 | Field selector for the write |
| csr_wr_data | input | 32 | CSR write data |
| csr_rd_data | output | 32 | Current register contents |
| exc_valid | input | 1 | Datapath completion carries flags |
| exc_flags | input | 5 | Exception flags to accumulate |
| chk_valid | input | 1 | Decode check request |
| chk_rm | input | 3 | Instruction static rounding field |
| chk_class | input | $clog2(NUM_CLASSES) | Operation class code |
| eff_rm | output | 3 | Resolved rounding mode |
| eff_acc | output | 2 | Resolved accuracy mode |
| chk_trap | output | 1 | Illegal-instruction trap request |

## Verification
Some properties are checked by assertions on every cycle: the reserved bits read zero, no trap appears without a request, a static rounding field passes straight through, a static-rounding check in mode 00 never traps, flags stay sticky while nothing writes them, and a flag write wins over accumulation. The full trap function can only be shown by the bench's sweep. The sweep covers every pair of stored accuracy mode and dynamic rounding mode, against every static field, class and request value. The bench instance uses a support matrix whose mode-00 row is empty, which shows that mode 00 is forced to supported. Bench scenarios also cover the reset value and the priority between writes and accumulation for each selector value.

// File: rtl/fpmode_pkg.sv
// Shared field layout, selector encoding and constants for the FP mode CSR.
// Assumes a 32-bit CSR with the used fields packed into the low bits.
package fpmode_pkg;
    localparam int CSR_W    = 32;
    localparam int FLAG_W   = 5;
    localparam int RM_W     = 3;
    localparam int ACC_W    = 2;
    localparam int USED_W   = FLAG_W + RM_W + ACC_W;
    localparam int NUM_MODES = 1 << ACC_W;

    localparam logic [RM_W-1:0]  RM_DYN       = 3'b111;
    localparam logic [RM_W-1:0]  RM_FIRST_BAD = 3'b101;
    localparam logic [ACC_W-1:0] ACC_IEEE     = 2'b00;

    typedef enum logic [1:0] {
        WSEL_ALL   = 2'b00,
        WSEL_FLAGS = 2'b01,
        WSEL_RM    = 2'b10,
        WSEL_ACC   = 2'b11
    } wsel_e;

    // Packed so the MSB-first order yields acc[9:8], rm[7:5], flags[4:0].
    typedef struct packed {
        logic [ACC_W-1:0]  acc;
        logic [RM_W-1:0]   rm;
        logic [FLAG_W-1:0] flags;
    } fpstate_t;
endpackage

// File: rtl/fpmode_state.sv
// Register storage for flags, dynamic rounding mode and accuracy mode.
// Applies field-selected CSR writes and sticky flag accumulation.
// A write that touches the flag field overrides accumulation in that cycle.
module fpmode_state
    import fpmode_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [1:0]           wr_sel,
    input  logic [CSR_W-1:0]     wr_data,
    input  logic                 exc_valid,
    input  logic [FLAG_W-1:0]    exc_flags,
    output fpstate_t             state_q
);
    fpstate_t state_d;

    // Next-state: accumulate first, then let a CSR write overwrite fields.
    always_comb begin
        state_d = state_q;
        if (exc_valid) begin
            state_d.flags = state_q.flags | exc_flags;
        end
        if (wr_en) begin
            unique case (wsel_e'(wr_sel))
                WSEL_ALL:   state_d       = fpstate_t'(wr_data[USED_W-1:0]);
                WSEL_FLAGS: state_d.flags = wr_data[FLAG_W-1:0];
                WSEL_RM:    state_d.rm    = wr_data[RM_W-1:0];
                WSEL_ACC:   state_d.acc   = wr_data[ACC_W-1:0];
                default:    state_d       = state_q;
            endcase
        end
    end

    // State register with synchronous active-low reset to all zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end
endmodule

// File: rtl/fpmode_support.sv
// Support-matrix lookup: is (accuracy mode, op class) implemented?
// Row 0 (IEEE mode) is forced to all-ones regardless of the parameter.
module fpmode_support
    import fpmode_pkg::*;
#(
    parameter int NUM_CLASSES = 8,
    localparam int CLS_W = (NUM_CLASSES > 1) ? $clog2(NUM_CLASSES) : 1,
    parameter logic [NUM_MODES*NUM_CLASSES-1:0] SUPPORT_MAP = '1
) (
    input  logic [ACC_W-1:0] acc,
    input  logic [CLS_W-1:0] cls,
    output logic             supported
);
    logic [NUM_CLASSES-1:0] row [NUM_MODES];

    // One row per accuracy mode; mode 0 is unconditionally supported.
    for (genvar m = 0; m < NUM_MODES; m++) begin : g_row
        if (m == 0) begin : g_ieee
            assign row[m] = '1;
        end else begin : g_cfg
            assign row[m] = SUPPORT_MAP[m*NUM_CLASSES +: NUM_CLASSES];
        end
    end

    // Index the selected row by class; out-of-range classes are unsupported.
    always_comb begin
        if (int'(cls) < NUM_CLASSES) begin
            supported = row[acc][cls];
        end else begin
            supported = 1'b0;
        end
    end
endmodule

// File: rtl/fpmode_resolve.sv
// Combinational resolution of effective rounding/accuracy and trap request.
// Assumes 'supported' already reflects the current accuracy mode and class.
module fpmode_resolve
    import fpmode_pkg::*;
(
    input  logic             chk_valid,
    input  logic [RM_W-1:0]  chk_rm,
    input  logic [RM_W-1:0]  dyn_rm,
    input  logic [ACC_W-1:0] dyn_acc,
    input  logic             supported,
    output logic [RM_W-1:0]  eff_rm,
    output logic [ACC_W-1:0] eff_acc,
    output logic             trap
);
    logic use_dyn;
    logic bad_dyn;

    // Select static or dynamic rounding and flag an invalid dynamic value.
    always_comb begin
        use_dyn = (chk_rm == RM_DYN);
        eff_rm  = use_dyn ? dyn_rm : chk_rm;
        bad_dyn = use_dyn && (dyn_rm >= RM_FIRST_BAD);
        eff_acc = dyn_acc;
        trap    = chk_valid && (bad_dyn || !supported);
    end
endmodule

// File: rtl/fpmode_csr.sv
// Top level of the FP mode CSR: storage, support lookup and decode check.
// Reads return the packed fields zero-extended; reserved bits read zero.
module fpmode_csr
    import fpmode_pkg::*;
#(
    parameter int NUM_CLASSES = 8,
    localparam int CLS_W = (NUM_CLASSES > 1) ? $clog2(NUM_CLASSES) : 1,
    parameter logic [NUM_MODES*NUM_CLASSES-1:0] SUPPORT_MAP = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csr_wr_en,
    input  logic [1:0]        csr_wr_sel,
    input  logic [CSR_W-1:0]  csr_wr_data,
    output logic [CSR_W-1:0]  csr_rd_data,
    input  logic              exc_valid,
    input  logic [FLAG_W-1:0] exc_flags,
    input  logic              chk_valid,
    input  logic [RM_W-1:0]   chk_rm,
    input  logic [CLS_W-1:0]  chk_class,
    output logic [RM_W-1:0]   eff_rm,
    output logic [ACC_W-1:0]  eff_acc,
    output logic              chk_trap
);
    fpstate_t state_q;
    logic     supported;

    fpmode_state u_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (csr_wr_en),
        .wr_sel    (csr_wr_sel),
        .wr_data   (csr_wr_data),
        .exc_valid (exc_valid),
        .exc_flags (exc_flags),
        .state_q   (state_q)
    );

    fpmode_support #(
        .NUM_CLASSES (NUM_CLASSES),
        .SUPPORT_MAP (SUPPORT_MAP)
    ) u_support (
        .acc       (state_q.acc),
        .cls       (chk_class),
        .supported (supported)
    );

    fpmode_resolve u_resolve (
        .chk_valid (chk_valid),
        .chk_rm    (chk_rm),
        .dyn_rm    (state_q.rm),
        .dyn_acc   (state_q.acc),
        .supported (supported),
        .eff_rm    (eff_rm),
        .eff_acc   (eff_acc),
        .trap      (chk_trap)
    );

    // Read path: used fields in the low bits, reserved bits tied to zero.
    always_comb begin
        csr_rd_data = {{(CSR_W-USED_W){1'b0}}, state_q};
    end
endmodule

// File: rtl/fpmode_csr_chk.sv
// Assertion checker for fpmode_csr, attached by bind below.
// Observes only top-level ports.
module fpmode_csr_chk
    import fpmode_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              csr_wr_en,
    input logic [1:0]        csr_wr_sel,
    input logic [CSR_W-1:0]  csr_wr_data,
    input logic [CSR_W-1:0]  csr_rd_data,
    input logic              chk_valid,
    input logic [RM_W-1:0]   chk_rm,
    input logic [RM_W-1:0]   eff_rm,
    input logic [ACC_W-1:0]  eff_acc,
    input logic              chk_trap
);
    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        csr_rd_data[CSR_W-1:USED_W] == '0);

    a_r10_no_trap_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_valid |-> !chk_trap);

    a_r6_static_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_rm != RM_DYN) |-> (eff_rm == chk_rm));

    a_r9_ieee_static_ok: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && chk_rm != RM_DYN && eff_acc == ACC_IEEE) |-> !chk_trap);

    a_r4_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !csr_wr_en |=> ((csr_rd_data[FLAG_W-1:0] & $past(csr_rd_data[FLAG_W-1:0]))
                        == $past(csr_rd_data[FLAG_W-1:0])));

    a_r5_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_wr_en && csr_wr_sel == WSEL_FLAGS)
        |=> (csr_rd_data[FLAG_W-1:0] == $past(csr_wr_data[FLAG_W-1:0])));
endmodule

bind fpmode_csr fpmode_csr_chk u_fpmode_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .csr_wr_en   (csr_wr_en),
    .csr_wr_sel  (csr_wr_sel),
    .csr_wr_data (csr_wr_data),
    .csr_rd_data (csr_rd_data),
    .chk_valid   (chk_valid),
    .chk_rm      (chk_rm),
    .eff_rm      (eff_rm),
    .eff_acc     (eff_acc),
    .chk_trap    (chk_trap)
);

// File: tb/fpmode_csr_tb_top.sv
// Self-checking bench: directed register tests plus an exhaustive sweep
// of accuracy mode x dynamic rounding x static field x class x valid.
module fpmode_csr_tb_top;
    localparam int          NC  = 8;
    localparam logic [31:0] MAP = 32'h81_3C_E7_00;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_wr_en = 1'b0;
    logic [1:0]  csr_wr_sel = 2'b00;
    logic [31:0] csr_wr_data = '0;
    logic [31:0] csr_rd_data;
    logic        exc_valid = 1'b0;
    logic [4:0]  exc_flags = '0;
    logic        chk_valid = 1'b0;
    logic [2:0]  chk_rm = '0;
    logic [2:0]  chk_class = '0;
    logic [2:0]  eff_rm;
    logic [1:0]  eff_acc;
    logic        chk_trap;

    int n_checks = 0;
    int n_errs   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    fpmode_csr #(.NUM_CLASSES(NC), .SUPPORT_MAP(MAP)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .csr_wr_en(csr_wr_en), .csr_wr_sel(csr_wr_sel), .csr_wr_data(csr_wr_data),
        .csr_rd_data(csr_rd_data),
        .exc_valid(exc_valid), .exc_flags(exc_flags),
        .chk_valid(chk_valid), .chk_rm(chk_rm), .chk_class(chk_class),
        .eff_rm(eff_rm), .eff_acc(eff_acc), .chk_trap(chk_trap)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One clocked cycle: drive at negedge, clock in, settle at next negedge.
    task automatic cycle(input logic we, input logic [1:0] sel, input logic [31:0] wd,
                         input logic ev, input logic [4:0] ef);
        @(negedge clk);
        csr_wr_en = we; csr_wr_sel = sel; csr_wr_data = wd;
        exc_valid = ev; exc_flags = ef;
        @(negedge clk);
        csr_wr_en = 1'b0; exc_valid = 1'b0;
    endtask

    function automatic bit supp(input int a, input int c);
        return (a == 0) || MAP[a*NC + c];
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset", csr_rd_data, 32'h0);

        // R4: accumulate and sticky; ignored when exc_valid low
        cycle(1'b0, 2'b00, '0, 1'b1, 5'h01);
        check("R4 acc1", csr_rd_data, 32'h01);
        cycle(1'b0, 2'b00, '0, 1'b1, 5'h04);
        check("R4 acc2", csr_rd_data, 32'h05);
        cycle(1'b0, 2'b00, '0, 1'b0, 5'h1A);
        check("R4 ignored", csr_rd_data, 32'h05);

        // R5: flag write beats accumulation; rm write does not
        cycle(1'b1, 2'b01, 32'hFFFF_FFE0, 1'b1, 5'h10);
        check("R5 flags write wins", csr_rd_data, 32'h00);
        cycle(1'b1, 2'b10, 32'h0000_0003, 1'b1, 5'h02);
        check("R5 rm write + acc", csr_rd_data, 32'h62);
        cycle(1'b1, 2'b00, 32'h0000_0155, 1'b1, 5'h08);
        check("R5 full write wins", csr_rd_data, 32'h155);

        // R3: accuracy-only write keeps other fields
        cycle(1'b1, 2'b11, 32'hFFFF_FFFE, 1'b0, 5'h00);
        check("R3 acc only", csr_rd_data, 32'h255);
        // R2: reserved bits ignored on full write
        cycle(1'b1, 2'b00, 32'hFFFF_FFFF, 1'b0, 5'h00);
        check("R2 reserved", csr_rd_data, 32'h3FF);

        // Exhaustive sweep over decode check
        for (int a = 0; a < 4; a++) begin
            for (int d = 0; d < 8; d++) begin
                cycle(1'b1, 2'b00, 32'((a << 8) | (d << 5) | 5'h0B), 1'b0, 5'h00);
                check("R3 full write", csr_rd_data, 32'((a << 8) | (d << 5) | 5'h0B));
                for (int c = 0; c < NC; c++) begin
                    for (int r = 0; r < 8; r++) begin
                        for (int v = 0; v < 2; v++) begin
                            logic [2:0] erm;
                            bit         etrap;
                            chk_valid = v[0]; chk_rm = r[2:0]; chk_class = c[2:0];
                            #1;
                            erm   = (r == 7) ? d[2:0] : r[2:0];
                            etrap = (v == 1) && (((r == 7) && (d >= 5)) || !supp(a, c));
                            check("R6 eff_rm", {29'd0, eff_rm}, {29'd0, erm});
                            check("R8 eff_acc", {30'd0, eff_acc}, 32'(a));
                            if (v == 0)
                                check("R10 idle", {31'd0, chk_trap}, 32'(etrap));
                            else if (r == 7 && d >= 5)
                                check("R7 bad dyn", {31'd0, chk_trap}, 32'(etrap));
                            else if (a == 0)
                                check("R9 ieee", {31'd0, chk_trap}, 32'(etrap));
                            else
                                check("R8 matrix", {31'd0, chk_trap}, 32'(etrap));
                        end
                    end
                end
                chk_valid = 1'b0;
            end
        end

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_errs++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
            $finish;
        end
    end
endmodule